// File: doc/BRIEF.md
# ADC Conversion Group Flag and Interrupt Logic

This block keeps the status and interrupt flags of one conversion group of an analog-to-digital sequencer and presents them as a 32-bit flag word on a simple register read/write port. Around it sit the converter, the results buffer, the channel sequencer and the bus fabric. Each of them reports to this block through plain strobes and levels: a conversion-done event, a group-complete pulse, the single-conversion mode bit, the buffer empty and overrun status, a buffer-read strobe with its FIFO read-mode qualifier, a channel-select write strobe and a programmed threshold.

The group-end flag records that every selected channel has been converted, but only in single-conversion mode. Four separate events clear it. The threshold flag tracks a saturating count of completed conversions that are still unread against the programmed level. Each of these two flags drives an interrupt request. The request is a one-cycle pulse on the flag's rising edge, gated by its own enable. The buffer empty and overrun bits are read-only mirrors.

Flag word layout (bit positions are decoded by software): bit 3 is group end, bit 2 is buffer empty, bit 1 is buffer overrun, bit 0 is threshold reached, and bits 31..4 are zero. The flag word is decoded at offset 0x3C. Bit 0 of a separate group status register at offset 0x68 is a second write-1 clear for group end.

Top module: `adc_grp_flags`

## Requirements
- R1: A read at offset 0x3C returns the flag word with bits 31..4 at zero. A read at any other offset returns zero. Writes to bits 31..4 change nothing.
- R2: While reset is applied, and after it, the flag word is 0x4 (buffer-empty bit 1, all others 0) whatever the status inputs are, and both interrupt requests are 0.
- R3: A group-complete pulse with single-conversion mode 1 sets bit 3 at the next clock edge. With single-conversion mode 0, the pulse leaves bit 3 unchanged.
- R4: Bit 3 clears at the next edge on any of these: a write to 0x3C with data bit 3 = 1; a write to 0x68 with data bit 0 = 1; a buffer read while FIFO read mode = 1; a channel-select write. A buffer read with FIFO read mode = 0 does not clear it, and neither does a 0x68 write with bit 0 = 0.
- R5: When a set event and a clear event for bit 3 or bit 0 fall in the same cycle, the flag ends up 1.
- R6: Bits 2 and 1 show the buffer-empty and buffer-overrun inputs as sampled at the previous clock edge. Writing to those bits has no effect.
- R7: A completed-conversion count of CNT_W bits rises by 1 on each conversion-done event. It falls by 1 on each buffer read in FIFO read mode. When both occur in the same cycle it is unchanged. It saturates at 0 and at 2^CNT_W-1, and it resets to 0.
- R8: Bit 0 sets on a conversion-done event when the resulting count is at or above the threshold. It clears when the count is below the threshold, or when 1 is written to bit 0 of 0x3C. Writing 0 to bit 0 leaves it unchanged. After a write-1 clear with the count still at or above the threshold, the next conversion-done event sets it again.
- R9: The group-end request is high for exactly one cycle, in the first cycle that bit 3 reads 1, provided the end enable was 1 before that edge. The threshold request follows the same rule for bit 0. A flag that stays set produces no further pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| convDone | input | 1 | One conversion of the group completed |
| groupDone | input | 1 | All selected channels of the group converted |
| singleMode | input | 1 | Group runs in single-conversion mode |
| bufRead | input | 1 | One result read from the results buffer |
| fifoReadMode | input | 1 | Buffer is being read in FIFO mode |
| chanSelWr | input | 1 | New channel selection written |
| bufEmpty | input | 1 | Results buffer is empty |
| bufOverrun | input | 1 | Results buffer has overrun |
| thrLevel | input | 4 | Programmed conversion-count threshold |
| endIntEn | input | 1 | Group-end interrupt enable |
| thrIntEn | input | 1 | Threshold interrupt enable |
| endIrq | output | 1 | Group-end interrupt request pulse |
| thrIrq | output | 1 | Threshold interrupt request pulse |

## Verification
The hardest state to reach from the ports is the completed-conversion count at each of its saturation limits with every possible threshold. The count is not visible directly, so it can only be seen through bit 0. The bench sweeps every threshold value of a 4-bit count. For each one it drives more conversion events than the count can hold, then more FIFO reads than are needed to empty it, and then one more conversion. After every step it compares bit 0 and the threshold request with a bench-side counter, so an off-by-one at either limit, or in the comparison, changes the flag at a predictable step. The same-cycle collisions (set against clear, increment against decrement) are forced explicitly with strobes driven together.

// File: rtl/adc_grp_pkg.sv
package adc_grp_pkg;

  localparam int FLAG_W = 4;

  localparam int BIT_THR  = 0;
  localparam int BIT_OVR  = 1;
  localparam int BIT_EMP  = 2;
  localparam int BIT_END  = 3;

  typedef struct packed {
    logic endSet;   // group complete in single-conversion mode
    logic endClr;   // any of the four clear sources
    logic thrW1c;   // write-1 clear of threshold flag
    logic cntUp;    // conversion completed
    logic cntDn;    // FIFO-mode buffer read
  } grpStrobes_t;

endpackage

// File: rtl/adc_grp_ctrl.sv
module adc_grp_ctrl
  import adc_grp_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter logic [7:0]  FLAG_OFFSET = 8'h3C,
  parameter logic [7:0]  STAT_OFFSET = 8'h68
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              convDone,
  input  logic              groupDone,
  input  logic              singleMode,
  input  logic              bufRead,
  input  logic              fifoReadMode,
  input  logic              chanSelWr,
  output grpStrobes_t       strobes
);

  logic flagHit;
  logic statHit;
  logic fifoPop;
  logic flagW1cEnd;
  logic statW1cEnd;

  always_comb begin
    flagHit    = regWr && (regAddr == FLAG_OFFSET[ADDR_W-1:0]);
    statHit    = regWr && (regAddr == STAT_OFFSET[ADDR_W-1:0]);
    fifoPop    = bufRead && fifoReadMode;
    flagW1cEnd = flagHit && regWdata[BIT_END];
    statW1cEnd = statHit && regWdata[0];
  end

  always_comb begin
    strobes        = '0;
    strobes.endSet = groupDone && singleMode;
    strobes.endClr = flagW1cEnd || statW1cEnd || fifoPop || chanSelWr;
    strobes.thrW1c = flagHit && regWdata[BIT_THR];
    strobes.cntUp  = convDone;
    strobes.cntDn  = fifoPop;
  end

endmodule

// File: rtl/adc_grp_dp.sv
module adc_grp_dp
  import adc_grp_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          CNT_W       = 4,
  parameter logic [7:0]  FLAG_OFFSET = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  grpStrobes_t       strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              bufEmpty,
  input  logic              bufOverrun,
  input  logic [CNT_W-1:0]  thrLevel,
  input  logic              endIntEn,
  input  logic              thrIntEn,
  output logic [FLAG_W-1:0] flagWord,
  output logic [DATA_W-1:0] regRdata,
  output logic              endIrq,
  output logic              thrIrq
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int               PAD_W   = DATA_W - FLAG_W;

  logic [CNT_W-1:0] convCnt, convCntNext;
  logic             endFlag, endFlagNext;
  logic             thrFlag, thrFlagNext;
  logic             emptyQ, overrunQ;

  // saturating up/down count of completed, unread conversions
  always_comb begin
    convCntNext = convCnt;
    unique case ({strobes.cntUp, strobes.cntDn})
      2'b10:   if (convCnt != CNT_MAX) convCntNext = convCnt + 1'b1;
      2'b01:   if (convCnt != '0)      convCntNext = convCnt - 1'b1;
      default: convCntNext = convCnt;
    endcase
  end

  // group end: set has priority over every clear source
  always_comb begin
    if (strobes.endSet)      endFlagNext = 1'b1;
    else if (strobes.endClr) endFlagNext = 1'b0;
    else                     endFlagNext = endFlag;
  end

  // threshold: sets on a conversion reaching the level
  always_comb begin
    if (strobes.cntUp && (convCntNext >= thrLevel)) thrFlagNext = 1'b1;
    else if (strobes.thrW1c)                        thrFlagNext = 1'b0;
    else if (convCntNext < thrLevel)                thrFlagNext = 1'b0;
    else                                            thrFlagNext = thrFlag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convCnt  <= '0;
      endFlag  <= 1'b0;
      thrFlag  <= 1'b0;
      emptyQ   <= 1'b1;
      overrunQ <= 1'b0;
      endIrq   <= 1'b0;
      thrIrq   <= 1'b0;
    end else begin
      convCnt  <= convCntNext;
      endFlag  <= endFlagNext;
      thrFlag  <= thrFlagNext;
      emptyQ   <= bufEmpty;
      overrunQ <= bufOverrun;
      endIrq   <= endIntEn && endFlagNext && !endFlag;
      thrIrq   <= thrIntEn && thrFlagNext && !thrFlag;
    end
  end

  always_comb begin
    flagWord          = '0;
    flagWord[BIT_END] = endFlag;
    flagWord[BIT_EMP] = emptyQ;
    flagWord[BIT_OVR] = overrunQ;
    flagWord[BIT_THR] = thrFlag;
  end

  always_comb begin
    if (regAddr == FLAG_OFFSET[ADDR_W-1:0]) regRdata = {{PAD_W{1'b0}}, flagWord};
    else                                    regRdata = '0;
  end

endmodule

// File: rtl/adc_grp_flags.sv
module adc_grp_flags
  import adc_grp_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          CNT_W       = 4,
  parameter logic [7:0]  FLAG_OFFSET = 8'h3C,
  parameter logic [7:0]  STAT_OFFSET = 8'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              convDone,
  input  logic              groupDone,
  input  logic              singleMode,
  input  logic              bufRead,
  input  logic              fifoReadMode,
  input  logic              chanSelWr,
  input  logic              bufEmpty,
  input  logic              bufOverrun,
  input  logic [CNT_W-1:0]  thrLevel,
  input  logic              endIntEn,
  input  logic              thrIntEn,
  output logic              endIrq,
  output logic              thrIrq
);

  grpStrobes_t       strobes;
  logic [FLAG_W-1:0] flagWord;

  adc_grp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FLAG_OFFSET(FLAG_OFFSET), .STAT_OFFSET(STAT_OFFSET)
  ) u_ctrl (
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .convDone(convDone), .groupDone(groupDone), .singleMode(singleMode),
    .bufRead(bufRead), .fifoReadMode(fifoReadMode), .chanSelWr(chanSelWr),
    .strobes(strobes)
  );

  adc_grp_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FLAG_OFFSET(FLAG_OFFSET)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .regAddr(regAddr),
    .bufEmpty(bufEmpty), .bufOverrun(bufOverrun), .thrLevel(thrLevel),
    .endIntEn(endIntEn), .thrIntEn(thrIntEn),
    .flagWord(flagWord), .regRdata(regRdata),
    .endIrq(endIrq), .thrIrq(thrIrq)
  );

endmodule

// File: rtl/adc_grp_flags_chk.sv
module adc_grp_flags_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] regRdata,
  input logic              groupDone,
  input logic              singleMode,
  input logic              chanSelWr,
  input logic              bufEmpty,
  input logic              bufOverrun,
  input logic              endIntEn,
  input logic              endIrq,
  input logic              thrIrq,
  input logic [3:0]        flagWord
);

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    regRdata[DATA_W-1:4] == '0);

  assert_end_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (groupDone && !singleMode && !chanSelWr) |=> $stable(flagWord[3]) || !flagWord[3]);

  assert_chansel_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chanSelWr && !(groupDone && singleMode)) |=> !flagWord[3]);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (groupDone && singleMode) |=> flagWord[3]);

  assert_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flagWord[2] == $past(bufEmpty)) && (flagWord[1] == $past(bufOverrun)));

  assert_end_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    endIrq |-> $rose(flagWord[3]));

  assert_thr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thrIrq |-> $rose(flagWord[0]));

  assert_end_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flagWord[3]) && $past(endIntEn)) |-> endIrq);

endmodule

bind adc_grp_flags adc_grp_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .regRdata(regRdata),
  .groupDone(groupDone), .singleMode(singleMode), .chanSelWr(chanSelWr),
  .bufEmpty(bufEmpty), .bufOverrun(bufOverrun), .endIntEn(endIntEn),
  .endIrq(endIrq), .thrIrq(thrIrq), .flagWord(flagWord)
);

// File: tb/tb_adc_grp_flags.sv
`timescale 1ns/1ps
module tb_adc_grp_flags;

  localparam logic [7:0] FLAG_A = 8'h3C;
  localparam logic [7:0] STAT_A = 8'h68;
  localparam int         CMAX   = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  regAddr = FLAG_A;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        convDone = 0, groupDone = 0, singleMode = 0;
  logic        bufRead = 0, fifoReadMode = 0, chanSelWr = 0;
  logic        bufEmpty = 1, bufOverrun = 0;
  logic [3:0]  thrLevel = '0;
  logic        endIntEn = 0, thrIntEn = 0;
  logic        endIrq, thrIrq;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  adc_grp_flags dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .convDone(convDone),
    .groupDone(groupDone), .singleMode(singleMode), .bufRead(bufRead),
    .fifoReadMode(fifoReadMode), .chanSelWr(chanSelWr), .bufEmpty(bufEmpty),
    .bufOverrun(bufOverrun), .thrLevel(thrLevel), .endIntEn(endIntEn),
    .thrIntEn(thrIntEn), .endIrq(endIrq), .thrIrq(thrIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    tick();
    regWr = 1'b0; regWdata = '0; regAddr = FLAG_A;
    #0.5;
  endtask

  task automatic pulse(input bit conv, input bit rd, input bit grp, input bit sel);
    convDone = conv; bufRead = rd; groupDone = grp; chanSelWr = sel;
    tick();
    convDone = 0; bufRead = 0; groupDone = 0; chanSelWr = 0;
  endtask

  task automatic setEnd();
    singleMode = 1;
    pulse(0, 0, 1, 0);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int expCnt;
    bit expThr, prevThr;

    // R2: reset value independent of status inputs
    bufEmpty = 0; bufOverrun = 1;
    tick();
    chk("R2 flag word in reset", regRdata, 32'h4);
    chk("R2 irqs in reset", {30'b0, endIrq, thrIrq}, 32'h0);
    bufEmpty = 1; bufOverrun = 0;
    doReset();
    chk("R2 flag word after reset", regRdata, 32'h4);

    // R1: other offsets read zero; upper bits ignore writes
    regAddr = STAT_A; #0.5;
    chk("R1 other offset reads zero", regRdata, 32'h0);
    regAddr = FLAG_A; #0.5;
    regWrite(FLAG_A, 32'hFFFF_FFF0);
    chk("R1 upper bits stay zero", regRdata, 32'h4);

    // R6: mirrors, writes ignored
    bufEmpty = 0; bufOverrun = 1;
    tick();
    chk("R6 mirror empty0 overrun1", regRdata, 32'h2);
    regWrite(FLAG_A, 32'h0000_0006);
    chk("R6 write to bits 2,1 ignored", regRdata, 32'h2);
    bufEmpty = 1; bufOverrun = 0;
    tick();
    chk("R6 mirror empty1 overrun0", regRdata, 32'h4);

    // R3: group end only in single mode
    endIntEn = 1;
    singleMode = 0;
    pulse(0, 0, 1, 0);
    chk("R3 continuous mode no set", regRdata[3], 1'b0);
    chk("R9 no pulse without flag", endIrq, 1'b0);
    singleMode = 1;
    pulse(0, 0, 1, 0);
    chk("R3 single mode sets bit 3", regRdata[3], 1'b1);
    chk("R9 end pulse on rise", endIrq, 1'b1);
    tick();
    chk("R9 end pulse one cycle", endIrq, 1'b0);
    chk("R9 flag held", regRdata[3], 1'b1);
    pulse(0, 0, 1, 0);
    chk("R9 no pulse when already set", endIrq, 1'b0);

    // R4: four clear paths and non-clears
    regWrite(FLAG_A, 32'h8);
    chk("R4 clear by flag write bit3", regRdata[3], 1'b0);
    setEnd();
    regWrite(STAT_A, 32'h2);
    chk("R4 status write bit0=0 keeps", regRdata[3], 1'b1);
    regWrite(STAT_A, 32'h1);
    chk("R4 clear by status write bit0", regRdata[3], 1'b0);
    setEnd();
    fifoReadMode = 0;
    pulse(0, 1, 0, 0);
    chk("R4 non-FIFO read keeps", regRdata[3], 1'b1);
    fifoReadMode = 1;
    pulse(0, 1, 0, 0);
    chk("R4 clear by FIFO read", regRdata[3], 1'b0);
    setEnd();
    pulse(0, 0, 0, 1);
    chk("R4 clear by channel select write", regRdata[3], 1'b0);

    // R5: set wins on collision
    pulse(0, 0, 1, 1);
    chk("R5 set beats channel select", regRdata[3], 1'b1);
    regWrite(FLAG_A, 32'h8);
    regAddr = FLAG_A; regWdata = 32'h8; regWr = 1; groupDone = 1;
    tick();
    regWr = 0; groupDone = 0; regWdata = 0;
    chk("R5 set beats write clear", regRdata[3], 1'b1);
    regWrite(FLAG_A, 32'h8);

    // R9: enable low gives no pulse
    endIntEn = 0;
    setEnd();
    chk("R9 end pulse gated", endIrq, 1'b0);
    chk("R3 flag set with enable low", regRdata[3], 1'b1);

    // R7/R8/R9: sweep every threshold through both saturation limits
    thrIntEn = 1;
    for (int t = 0; t <= CMAX; t++) begin
      thrLevel = t[3:0];
      doReset();
      expCnt = 0; expThr = 0;
      for (int k = 1; k <= CMAX + 3; k++) begin
        prevThr = expThr;
        if (expCnt < CMAX) expCnt++;
        expThr = (expCnt >= t);
        pulse(1, 0, 0, 0);
        chk($sformatf("R7 R8 up t=%0d k=%0d", t, k), regRdata[0], expThr);
        chk($sformatf("R9 thr pulse t=%0d k=%0d", t, k), thrIrq, expThr && !prevThr);
      end
      for (int d = 1; d <= CMAX + 2; d++) begin
        if (expCnt > 0) expCnt--;
        if (expCnt < t) expThr = 0;
        pulse(0, 1, 0, 0);
        chk($sformatf("R7 R8 down t=%0d d=%0d", t, d), regRdata[0], expThr);
      end
      prevThr = expThr;
      expCnt = 1;
      expThr = (expCnt >= t);
      pulse(1, 0, 0, 0);
      chk($sformatf("R7 floor t=%0d", t), regRdata[0], expThr);
      chk($sformatf("R9 thr pulse floor t=%0d", t), thrIrq, expThr && !prevThr);
    end

    // R8: write-1 clear, write-0 no effect, re-set on next conversion
    thrLevel = 4'd3;
    doReset();
    for (int k = 0; k < 5; k++) pulse(1, 0, 0, 0);
    chk("R8 set at count 5 thr 3", regRdata[0], 1'b1);
    regWrite(FLAG_A, 32'h0);
    chk("R8 write 0 keeps", regRdata[0], 1'b1);
    regWrite(FLAG_A, 32'h1);
    chk("R8 write 1 clears", regRdata[0], 1'b0);
    pulse(1, 0, 0, 0);
    chk("R8 re-set on next conversion", regRdata[0], 1'b1);
    chk("R9 thr pulse on re-set", thrIrq, 1'b1);
    // R5: conversion beats write-1 clear
    regAddr = FLAG_A; regWdata = 32'h1; regWr = 1; convDone = 1;
    tick();
    regWr = 0; convDone = 0; regWdata = 0;
    chk("R5 conversion beats thr clear", regRdata[0], 1'b1);

    // R7: simultaneous up and down leaves count unchanged (count 7 here)
    pulse(1, 1, 0, 0);
    thrLevel = 4'd8; tick();
    chk("R7 up+down keeps count below 8", regRdata[0], 1'b0);
    thrLevel = 4'd7; pulse(1, 1, 0, 0);
    chk("R7 up+down count still 7", regRdata[0], 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule